// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This block is a streaming per-pixel stage that brings three 12-bit colour components (RGB or YCbCr) down to 6, 8 or 10 significant bits. Each component is either cut to the target depth or first has pseudo-random noise added and is then cut. Results stay left-aligned in 12 bits with the discarded low bits forced to zero, so later stages see one data format whatever the depth.

The noise for each channel comes from its own 28-bit linear feedback shift register. Either all three share one feedback polynomial or each channel uses a different one. The registers can be reseeded at every frame start, and in that mode a small frame counter is mixed into the noise so that the pattern changes from frame to frame. A simple write port loads a staging control word and three seeds. The staged values become live only on a start-of-frame pulse, so settings never change in the middle of a frame.

Top module: `dither_reducer`

## Requirements
- R1: While reset is asserted and right after it, `vld_o` is 0, all outputs are 0, and the live settings are all zero (pass-through).
- R2: `vld_o` repeats `vld_i` one clock later. A component output changes only one clock after a cycle with `vld_i` high, and otherwise holds its value.
- R3: A write with `cfg_addr_i`=0 stages the control word: bit 0 truncate enable, bits 2:1 truncate depth, bit 3 dither enable, bits 5:4 dither depth, bit 6 per-frame reseed, bit 7 per-channel polynomial, bit 8 4:2:2 mode. Addresses 1, 2 and 3 stage the 28-bit seeds of channels 0, 1 and 2. Staged values become live on a cycle with `sof_i` high, and a pixel in that same cycle already uses them. Writes without a following `sof_i` leave the outputs unchanged.
- R4: With dither and truncation both off and 4:2:2 mode off, every output equals its input.
- R5: Depth code 0 keeps the top 6 bits, code 1 keeps 8, and codes 2 and 3 keep 10. The remaining low bits of the output are 0.
- R6: In 4:2:2 mode, truncation ignores its enable bit. It applies whenever the truncate depth is 1 or 2, and never for depths 0 or 3.
- R7: With dither on, k = 6, 4 or 2 for dither depth 0, 1 or 2/3. The low k bits of the channel noise are added to the component. The sum saturates at 0xFFF and then its low k bits are cleared, so an all-ones input gives the largest code of that depth.
- R8: Each register shifts left and puts bit27 XOR bit(t-1) into bit 0. t is 3 for every channel in shared mode; in per-channel mode t is 3, 9 and 13 for channels 0, 1 and 2. A register steps once per valid pixel while dither is live, and the pixel uses the state from before that step.
- R9: On a `sof_i` cycle that turns dither on, a channel register loads its seed. With per-frame reseed it also loads its seed on every `sof_i` cycle while dither stays on. Otherwise the state continues across frames.
- R10: The channel noise is the low 12 bits of the register state XOR a 4-bit frame count. The count is 0 unless dither and per-frame reseed are both live. It starts at 0 on the frame that enables them and then steps at each `sof_i`. It wraps to 0 after 15 for dither depths 0 and 1, and after 3 for depths 2 and 3.
- R11: With dither and truncation both active, the dithered value is then cut to the truncation depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Staging write strobe |
| cfg_addr_i | input | 2 | Staging address: 0 control, 1..3 seeds |
| cfg_wdata_i | input | 28 | Staging write data |
| sof_i | input | 1 | Start-of-frame pulse, makes staged settings live |
| vld_i | input | 1 | Input pixel valid |
| ch0_i | input | 12 | Component 0 (R or Cr) |
| ch1_i | input | 12 | Component 1 (G or Y) |
| ch2_i | input | 12 | Component 2 (B or Cb) |
| vld_o | output | 1 | Output pixel valid |
| ch0_o | output | 12 | Reduced component 0 |
| ch1_o | output | 12 | Reduced component 1 |
| ch2_o | output | 12 | Reduced component 2 |

## Verification
The assertions check properties that hold on every cycle:
- the one-cycle valid delay and the hold of outputs between pixels;
- that live settings change only on a frame start;
- pass-through when everything is off;
- the cleared low bits at the coarsest truncation depth;
- saturation of an all-ones input;
- that register state does not move without a valid dithered pixel;
- the bounds of the frame counter.

The exact dithered values, the polynomials, seed reloads across frames, the frame-count wrap and the 4:2:2 override can only be shown by the bench. It compares every output against its own model over directed and random frames.

// File: rtl/dred_pkg.sv
package dred_pkg;

  localparam int FW          = 4;   // frame counter width
  localparam int FMAX_FINE   = 3;   // wrap point for the finest dither depth
  localparam int FMAX_COARSE = 15;  // wrap point for the two coarser depths

  // Staged/live control word; the packed order is the write-data bit layout.
  typedef struct packed {
    logic       ycc422;    // bit 8
    logic       per_chan;  // bit 7
    logic       frand;     // bit 6
    logic [1:0] ddepth;    // bits 5:4
    logic       dith_en;   // bit 3
    logic [1:0] tdepth;    // bits 2:1
    logic       trunc_en;  // bit 0
  } dred_ctrl_t;

  localparam int CTRL_W = $bits(dred_ctrl_t);

  // Number of low bits discarded for a depth code at component width cw.
  function automatic int disc_bits(input int cw, input logic [1:0] d);
    case (d)
      2'd0:    return cw - 6;
      2'd1:    return cw - 8;
      default: return cw - 10;
    endcase
  endfunction

endpackage

// File: rtl/dred_cfg.sv
module dred_cfg
  import dred_pkg::*;
#(
  parameter int LW  = 28,
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [LW-1:0]            wdata_i,
  input  logic                     sof_i,
  output dred_ctrl_t               act_o,
  output dred_ctrl_t               eff_o,
  output logic [NCH-1:0][LW-1:0]   seed_o
);

  dred_ctrl_t shd_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else if (we_i && addr_i == '0) begin
      shd_q <= dred_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // Seeds are staged only: they are consumed solely at frame start.
  for (genvar c = 0; c < NCH; c++) begin : g_seed
    logic [LW-1:0] seed_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seed_q <= '0;
      end else if (we_i && addr_i == AW'(c + 1)) begin
        seed_q <= wdata_i;
      end
    end
    assign seed_o[c] = seed_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (sof_i) begin
      act_q <= shd_q;
    end
  end

  // Settings seen by the datapath this cycle: staged copy on a frame start.
  assign act_o = act_q;
  assign eff_o = sof_i ? shd_q : act_q;

endmodule

// File: rtl/dred_noise.sv
module dred_noise
  import dred_pkg::*;
#(
  parameter int CW         = 12,
  parameter int LW         = 28,
  parameter int NCH        = 3,
  parameter int TAP_SHARED = 3,
  parameter int TAP_G      = 9,
  parameter int TAP_B      = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sof_i,
  input  logic                    vld_i,
  input  logic                    act_den_i,
  input  logic                    act_frand_i,
  input  logic                    eff_den_i,
  input  logic                    eff_frand_i,
  input  logic [1:0]              eff_ddepth_i,
  input  logic                    eff_perch_i,
  input  logic [NCH-1:0][LW-1:0]  seed_i,
  output logic [NCH-1:0][CW-1:0]  noise_o,
  output logic [FW-1:0]           fcnt_eff_o,
  output logic [FW-1:0]           fcnt_q_o,
  output logic [NCH-1:0][LW-1:0]  lfsr_o
);

  logic          load, adv, fr_cont;
  logic [FW-1:0] fcnt_q, fmax, fc_step, fcnt_eff;

  // Reload on the frame that turns dither on, or every frame with reseed.
  assign load = sof_i & eff_den_i & (eff_frand_i | ~act_den_i);
  assign adv  = vld_i & eff_den_i;

  assign fr_cont  = act_den_i & act_frand_i;
  assign fmax     = (eff_ddepth_i >= 2'd2) ? FW'(FMAX_FINE) : FW'(FMAX_COARSE);
  assign fc_step  = (fr_cont && fcnt_q < fmax) ? fcnt_q + 1'b1 : '0;
  assign fcnt_eff = !sof_i                     ? fcnt_q  :
                    (eff_den_i && eff_frand_i) ? fc_step : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) fcnt_q <= '0;
    else        fcnt_q <= fcnt_eff;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lfsr
    localparam int OWN = (c == 0) ? TAP_SHARED : (c == 1) ? TAP_G : TAP_B;
    logic [LW-1:0] q, src, stepped;

    assign src     = load ? seed_i[c] : q;
    assign stepped = {src[LW-2:0],
                      src[LW-1] ^ (eff_perch_i ? src[OWN-1] : src[TAP_SHARED-1])};

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= adv ? stepped : src;
    end

    assign noise_o[c] = src[CW-1:0];
    assign lfsr_o[c]  = q;
  end

  assign fcnt_eff_o = fcnt_eff;
  assign fcnt_q_o   = fcnt_q;

endmodule

// File: rtl/dred_lane.sv
module dred_lane
  import dred_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [CW-1:0] pix_i,
  input  logic [CW-1:0] noise_i,
  input  logic [FW-1:0] fcnt_i,
  input  logic          dith_en_i,
  input  logic [1:0]    ddepth_i,
  input  logic          trunc_en_i,
  input  logic [1:0]    tdepth_i,
  input  logic          ycc422_i,
  output logic [CW-1:0] pix_o
);

  function automatic logic [CW-1:0] low_mask(input int k);
    logic [CW-1:0] m;
    for (int i = 0; i < CW; i++) m[i] = (i < k);
    return m;
  endfunction

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] x,
                                            input logic [CW-1:0] n);
    logic [CW:0] s;
    s = {1'b0, x} + {1'b0, n};
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  logic [CW-1:0] dmask, tmask, noise, stage1, res;
  logic          tr_on;

  assign dmask  = low_mask(disc_bits(CW, ddepth_i));
  assign tmask  = low_mask(disc_bits(CW, tdepth_i));
  assign noise  = (noise_i ^ CW'(fcnt_i)) & dmask;
  assign stage1 = dith_en_i ? (sat_add(pix_i, noise) & ~dmask) : pix_i;
  assign tr_on  = ycc422_i ? (tdepth_i == 2'd1 || tdepth_i == 2'd2) : trunc_en_i;
  assign res    = tr_on ? (stage1 & ~tmask) : stage1;

  always_ff @(posedge clk) begin
    if (!rst_n)     pix_o <= '0;
    else if (vld_i) pix_o <= res;
  end

endmodule

// File: rtl/dither_reducer.sv
module dither_reducer
  import dred_pkg::*;
#(
  parameter int CW         = 12,
  parameter int LW         = 28,
  parameter int TAP_SHARED = 3,
  parameter int TAP_G      = 9,
  parameter int TAP_B      = 13,
  parameter int CFG_AW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [LW-1:0]     cfg_wdata_i,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [CW-1:0]     ch0_i,
  input  logic [CW-1:0]     ch1_i,
  input  logic [CW-1:0]     ch2_i,
  output logic              vld_o,
  output logic [CW-1:0]     ch0_o,
  output logic [CW-1:0]     ch1_o,
  output logic [CW-1:0]     ch2_o
);

  localparam int NCH = 3;

  dred_ctrl_t                act_ctrl, eff_ctrl;
  logic [NCH-1:0][LW-1:0]    seeds, lfsr_q;
  logic [NCH-1:0][CW-1:0]    noise, pix_in, pix_out;
  logic [FW-1:0]             fcnt_eff, fcnt_q;

  dred_cfg #(.LW(LW), .NCH(NCH), .AW(CFG_AW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .sof_i   (sof_i),
    .act_o   (act_ctrl),
    .eff_o   (eff_ctrl),
    .seed_o  (seeds)
  );

  dred_noise #(.CW(CW), .LW(LW), .NCH(NCH), .TAP_SHARED(TAP_SHARED),
               .TAP_G(TAP_G), .TAP_B(TAP_B)) u_noise (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_i        (sof_i),
    .vld_i        (vld_i),
    .act_den_i    (act_ctrl.dith_en),
    .act_frand_i  (act_ctrl.frand),
    .eff_den_i    (eff_ctrl.dith_en),
    .eff_frand_i  (eff_ctrl.frand),
    .eff_ddepth_i (eff_ctrl.ddepth),
    .eff_perch_i  (eff_ctrl.per_chan),
    .seed_i       (seeds),
    .noise_o      (noise),
    .fcnt_eff_o   (fcnt_eff),
    .fcnt_q_o     (fcnt_q),
    .lfsr_o       (lfsr_q)
  );

  assign pix_in = {ch2_i, ch1_i, ch0_i};

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    dred_lane #(.CW(CW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (vld_i),
      .pix_i      (pix_in[c]),
      .noise_i    (noise[c]),
      .fcnt_i     (fcnt_eff),
      .dith_en_i  (eff_ctrl.dith_en),
      .ddepth_i   (eff_ctrl.ddepth),
      .trunc_en_i (eff_ctrl.trunc_en),
      .tdepth_i   (eff_ctrl.tdepth),
      .ycc422_i   (eff_ctrl.ycc422),
      .pix_o      (pix_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  assign ch0_o = pix_out[0];
  assign ch1_o = pix_out[1];
  assign ch2_o = pix_out[2];

endmodule

// File: rtl/dred_chk.sv
module dred_chk
  import dred_pkg::*;
#(
  parameter int CW  = 12,
  parameter int LW  = 28,
  parameter int NCH = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vld_i,
  input logic                   sof_i,
  input logic [CW-1:0]          ch0_i,
  input logic [CW-1:0]          ch1_i,
  input logic [CW-1:0]          ch2_i,
  input logic                   vld_o,
  input logic [CW-1:0]          ch0_o,
  input logic [CW-1:0]          ch1_o,
  input logic [CW-1:0]          ch2_o,
  input dred_ctrl_t             act_ctrl,
  input logic [FW-1:0]          fcnt,
  input logic [NCH-1:0][LW-1:0] lfsr
);

  localparam logic [CW-1:0] LOW6 = {{6{1'b0}}, {(CW-6){1'b1}}};

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable({ch0_o, ch1_o, ch2_o}));

  assert_cfg_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(act_ctrl));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !sof_i && !act_ctrl.dith_en && !act_ctrl.trunc_en && !act_ctrl.ycc422)
    |=> (ch0_o == $past(ch0_i) && ch1_o == $past(ch1_i) && ch2_o == $past(ch2_i)));

  assert_coarse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !sof_i && act_ctrl.trunc_en && !act_ctrl.ycc422 && act_ctrl.tdepth == 2'd0)
    |=> ((ch0_o & LOW6) == '0 && (ch1_o & LOW6) == '0 && (ch2_o & LOW6) == '0));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !sof_i && act_ctrl.dith_en && act_ctrl.ddepth == 2'd0 &&
     !act_ctrl.trunc_en && !act_ctrl.ycc422 && ch0_i == '1)
    |=> ch0_o == ~LOW6);

  assert_lfsr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_i && (!vld_i || !act_ctrl.dith_en)) |=> $stable(lfsr));

  assert_fcnt_fine_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ctrl.dith_en && act_ctrl.frand && act_ctrl.ddepth >= 2'd2) |-> fcnt <= FW'(FMAX_FINE));
  assert_fcnt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_ctrl.dith_en && act_ctrl.frand) |-> fcnt == '0);

endmodule

bind dither_reducer dred_chk #(.CW(CW), .LW(LW), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vld_i    (vld_i),
  .sof_i    (sof_i),
  .ch0_i    (ch0_i),
  .ch1_i    (ch1_i),
  .ch2_i    (ch2_i),
  .vld_o    (vld_o),
  .ch0_o    (ch0_o),
  .ch1_o    (ch1_o),
  .ch2_o    (ch2_o),
  .act_ctrl (act_ctrl),
  .fcnt     (fcnt_q),
  .lfsr     (lfsr_q)
);

// File: tb/tb_dither_reducer.sv
module tb_dither_reducer;

  localparam int CW = 12;
  localparam int LW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [LW-1:0] wdata = '0;
  logic          sof = 1'b0, vld = 1'b0;
  logic [CW-1:0] i0 = '0, i1 = '0, i2 = '0;
  logic          vld_o;
  logic [CW-1:0] o0, o1, o2;

  always #5 clk = ~clk;

  dither_reducer dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .sof_i(sof), .vld_i(vld), .ch0_i(i0), .ch1_i(i1), .ch2_i(i2),
    .vld_o(vld_o), .ch0_o(o0), .ch1_o(o1), .ch2_o(o2)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state
  bit [8:0]    m_shd = '0, m_act = '0;
  int unsigned m_seed[3] = '{0, 0, 0};
  int unsigned m_lfsr[3] = '{0, 0, 0};
  int unsigned m_exp[3]  = '{0, 0, 0};
  int unsigned m_fc = 0;
  bit          m_expv = 1'b0;
  int          tap_own[3] = '{3, 9, 13};

  function automatic int unsigned nxt(int unsigned s, int t);
    int unsigned fb;
    fb = ((s >> 27) ^ (s >> (t - 1))) & 32'd1;
    return ((s << 1) | fb) & 32'h0FFF_FFFF;
  endfunction

  function automatic int disc(bit [1:0] d);
    return (d == 2'd0) ? 6 : (d == 2'd1) ? 4 : 2;
  endfunction

  function automatic int unsigned ref_px(int unsigned x, int unsigned raw, bit [8:0] a);
    int unsigned v;
    int k;
    bit tr;
    v = x;
    if (a[3]) begin
      k = disc(a[5:4]);
      v = x + (raw % (32'd1 << k));
      if (v > 4095) v = 4095;
      v = v - (v % (32'd1 << k));
    end
    tr = a[8] ? (a[2:1] == 2'd1 || a[2:1] == 2'd2) : a[0];
    if (tr) begin
      k = disc(a[2:1]);
      v = (v >> k) << k;
    end
    return v;
  endfunction

  function automatic int unsigned gp(int mode);
    if (mode == 1) return 32'hFFF;
    if (mode == 2) return 32'hFF0 + ($urandom % 16);
    return $urandom % 4096;
  endfunction

  task automatic chk(string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks the result.
  task automatic cyc(bit w, bit [1:0] a, int unsigned d, bit v, bit s,
                     int unsigned p0, int unsigned p1, int unsigned p2, string req);
    int unsigned px[3];
    px = '{p0, p1, p2};
    we = w; addr = a; wdata = d[27:0]; vld = v; sof = s;
    i0 = p0[11:0]; i1 = p1[11:0]; i2 = p2[11:0];
    if (s) begin
      bit ld;
      int unsigned mx;
      ld = m_shd[3] && (m_shd[6] || !m_act[3]);
      mx = (m_shd[5:4] >= 2'd2) ? 3 : 15;
      if (m_shd[3] && m_shd[6])
        m_fc = (m_act[3] && m_act[6] && m_fc < mx) ? m_fc + 1 : 0;
      else
        m_fc = 0;
      m_act = m_shd;
      if (ld) for (int c = 0; c < 3; c++) m_lfsr[c] = m_seed[c];
    end
    if (v) begin
      for (int c = 0; c < 3; c++) begin
        m_exp[c] = ref_px(px[c], (m_lfsr[c] & 32'hFFF) ^ m_fc, m_act);
        if (m_act[3]) m_lfsr[c] = nxt(m_lfsr[c], m_act[7] ? tap_own[c] : 3);
      end
    end
    m_expv = v;
    if (w) begin
      if (a == 2'd0) m_shd = d[8:0];
      else m_seed[a - 1] = d & 32'h0FFF_FFFF;
    end
    @(posedge clk);
    #2;
    chk("R2", "vld_o", vld_o, m_expv);
    chk(req, "ch0", o0, m_exp[0]);
    chk(req, "ch1", o1, m_exp[1]);
    chk(req, "ch2", o2, m_exp[2]);
    @(negedge clk);
  endtask

  task automatic wr(bit [1:0] a, int unsigned d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 0, 0, 0, "R2");
  endtask

  task automatic new_seeds();
    for (int c = 1; c <= 3; c++) wr(2'(c), ($urandom & 32'h0FFF_FFFF) | 32'd1);
  endtask

  task automatic frame(int unsigned ctrl, int n, int mode, string req);
    wr(2'd0, ctrl);
    for (int i = 0; i < n; i++) begin
      bit v;
      v = (i == 0) ? 1'b1 : (($urandom % 4) != 0);
      cyc(1'b0, 2'd0, 0, v, i == 0, gp(mode), gp(mode), gp(mode), req);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    // R1: outputs stay cleared while reset is held, even with input activity
    @(negedge clk);
    vld = 1'b1; i0 = 12'hABC; i1 = 12'h123; i2 = 12'hFFF; sof = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "vld_o in reset", vld_o, 0);
    chk("R1", "ch0 in reset", o0, 0);
    chk("R1", "ch2 in reset", o2, 0);
    vld = 1'b0; sof = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "vld_o after reset", vld_o, 0);
    chk("R1", "ch1 after reset", o1, 0);
    // R1/R4: live settings are zero after reset, so pixels pass unchanged
    for (int i = 0; i < 8; i++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b0, gp(0), gp(0), gp(0), "R1");

    // R4: everything off
    frame(9'h000, 30, 0, "R4");
    frame(9'h000, 20, 2, "R4");

    // R5: truncation at each depth code
    for (int d = 0; d < 4; d++) frame(32'h1 | (d << 1), 25, 0, "R5");

    // R6: 4:2:2 override, enable bit clear and set
    for (int d = 0; d < 4; d++) frame(32'h100 | (d << 1), 20, 0, "R6");
    frame(32'h101, 20, 0, "R6");

    // R8: shared and per-channel polynomials over several frames
    new_seeds();
    for (int d = 0; d < 3; d++) begin
      frame(32'h008 | (d << 4), 30, 0, "R8");
      frame(32'h008 | (d << 4), 30, 0, "R8");
    end
    for (int d = 0; d < 3; d++) frame(32'h088 | (d << 4), 40, 0, "R8");

    // R7: saturation near full scale
    frame(32'h008, 20, 1, "R7");
    frame(32'h018, 20, 2, "R7");
    frame(32'h028, 20, 2, "R7");

    // R9: new seeds without reseed mode are not picked up; re-enable loads them
    new_seeds();
    frame(32'h088, 20, 0, "R9");
    frame(32'h000, 6, 0, "R9");
    frame(32'h088, 20, 0, "R9");

    // R10: per-frame reseed with counter wrap at both depths
    new_seeds();
    for (int f = 0; f < 20; f++) frame(32'h048, 6, 0, "R10");
    for (int f = 0; f < 10; f++) frame(32'h068, 6, 0, "R10");
    for (int f = 0; f < 6; f++) frame(32'h0D8, 6, 0, "R10");

    // R3: staged writes with no frame start leave the live settings alone
    frame(32'h000, 5, 0, "R3");
    wr(2'd0, 32'h003);
    wr(2'd1, 32'h0ABCDEF);
    for (int i = 0; i < 15; i++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b0, gp(0), gp(0), gp(0), "R3");
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b1, gp(0), gp(0), gp(0), "R3");
    for (int i = 0; i < 10; i++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b0, gp(0), gp(0), gp(0), "R3");

    // R11: dither followed by truncation
    for (int dd = 0; dd < 3; dd++)
      for (int td = 0; td < 3; td++) frame(32'h009 | (dd << 4) | (td << 1), 12, 0, "R11");

    // Mixed random frames
    for (int f = 0; f < 40; f++) begin
      if (($urandom % 5) == 0) new_seeds();
      frame($urandom % 512, 5 + ($urandom % 30), $urandom % 3, "R7");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule